// File: doc/BRIEF.md
# Prime-Modulus Strided Vector Address Generator

This block turns one vector access request (a start word address, a signed stride and an element count) into a series of issue beats for a memory spread over a prime number of banks (17 by default). Each beat carries up to 16 lanes. Every lane holds the bank and the row inside that bank for one element. Word `w` sits in bank `w mod 17` at row `floor(w / 17)`. Both are computed with a true modulo and divide. They are not taken from address bits.

Because the bank count is prime, any stride that is not a multiple of 17 sends the 16 lanes of a beat to 16 different banks. This holds for power-of-two strides too, so such a run takes exactly ceil(count/16) beats. A stride that is a multiple of 17 (zero included) puts every element in the same bank. The block detects this, raises `conflict`, and serializes the beat. It issues the longest leading group of lanes whose banks are distinct, and the remaining elements follow in later beats in their original order. A one-cycle `done` pulse marks the end of each request.

Top module: `prime_stride_agu`

## Requirements
- R1: For every valid lane, `lane_bank` equals `w mod 17`. Element `e` (counted from 0) has address `w = start_addr + e*stride`, and lane `l` occupies bits `[l*5 +: 5]`.
- R2: For every valid lane, `lane_row` equals `floor(w / 17)`. Lane `l` occupies bits `[l*16 +: 16]`.
- R3: Elements leave in increasing index order. In each beat, lane 0 carries the lowest pending element and `lane_valid` is a contiguous mask starting at bit 0.
- R4: No two valid lanes of one beat name the same bank.
- R5: For a stride that is not a multiple of 17, a request of `count` elements takes exactly ceil(count/16) beats, and every beat except the last has all 16 lanes valid.
- R6: For a stride that is a multiple of 17 (including 0 and negative multiples), each beat carries one element. `conflict` is high on every beat where two or more elements were still pending, and low on the beat that carries the last element.
- R7: `conflict` stays low on every beat whose candidate lanes all fall in distinct banks.
- R8: `start_ready` is high exactly when no request is being issued. A `start_valid` raised while issuing is ignored and does not change the issued stream.
- R9: `done` is high for one cycle, the cycle after the final beat, with `issue_valid` low. A request with `count` = 0 produces no beat and raises `done` in the cycle after acceptance.
- R10: Negative strides walk downward through memory. Addresses are formed modulo 2^20 and must stay in range.
- R11: After reset the block is idle: `start_ready` high, and `issue_valid`, `lane_valid`, `conflict` and `done` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Block idle, request accepted this cycle if valid |
| start_addr | input | 20 | First element word address |
| start_stride | input | 16 | Signed element stride in words |
| start_count | input | 13 | Element count, 0 to 4096 |
| issue_valid | output | 1 | A beat is being issued this cycle |
| lane_valid | output | 16 | Per-lane valid mask |
| lane_bank | output | 80 | Per-lane bank index, 5 bits per lane |
| lane_row | output | 256 | Per-lane row inside the bank, 16 bits per lane |
| conflict | output | 1 | Candidate lanes collided on a bank; beat was cut short |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
Two pairs of functions can land in the same cycle. The first pair is bank-collision serialization and the final beat of a request. With a stride of 17, 34, 0 or -17, the last pending element arrives in a beat that has only one candidate, so `conflict` must drop in exactly the cycle that precedes `done`. A scoreboard that tracks pending elements judges the flag on every beat against the count still outstanding. The second pair is an active issue stream and a new request. A `start_valid` carrying different parameters is held high in the middle of a long run, and the scoreboard, filled from integer division and modulo, would show any disturbance of the bank and row values or of the beat count.

// File: rtl/prime_agu_pkg.sv
package prime_agu_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/prime_bank_map.sv
module prime_bank_map #(
    parameter int ADDR_W    = 20,
    parameter int NUM_BANKS = 17,
    parameter int BANK_W    = 5,
    parameter int ROW_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] word_addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);
    // Floor reciprocal scaled by 2^SHIFT; the estimate is q or q-1.
    localparam int SHIFT  = ADDR_W + 5;
    localparam int PROD_W = ADDR_W + SHIFT;
    localparam logic [SHIFT-1:0] RECIP = SHIFT'((64'd1 << SHIFT) / NUM_BANKS);
    localparam logic [ADDR_W:0]  NB_X  = (ADDR_W+1)'(NUM_BANKS);

    logic [ADDR_W-1:0] q_est;
    logic [ADDR_W:0]   rem_est;
    logic [ADDR_W-1:0] q_fix;
    logic [ADDR_W:0]   rem_fix;

    always_comb begin
        q_est   = ADDR_W'((PROD_W'(word_addr) * PROD_W'(RECIP)) >> SHIFT);
        rem_est = {1'b0, word_addr} - ((ADDR_W+1)'(q_est) * NB_X);
        if (rem_est >= NB_X) begin
            q_fix   = q_est + 1'b1;
            rem_fix = rem_est - NB_X;
        end else begin
            q_fix   = q_est;
            rem_fix = rem_est;
        end
        bank = BANK_W'(rem_fix);
        row  = ROW_W'(q_fix);
    end

    // R1: the bank index never reaches the bank count
    assert_bank_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bank < BANK_W'(NUM_BANKS));

    // R2: row and bank recompose the word address
    assert_row_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ADDR_W+1)'(row) * NB_X + (ADDR_W+1)'(bank)) == {1'b0, word_addr});

endmodule

// File: rtl/bank_group_scan.sv
module bank_group_scan #(
    parameter int LANES  = 16,
    parameter int BANK_W = 5,
    parameter int TAKE_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        cand_valid,
    input  logic [LANES*BANK_W-1:0] cand_bank,
    output logic [LANES-1:0]        grant,
    output logic [TAKE_W-1:0]       take,
    output logic                    repeat_seen
);
    logic [LANES-1:0] dup;
    logic             found;

    always_comb begin
        dup = '0;
        for (int i = 1; i < LANES; i++) begin
            for (int j = 0; j < i; j++) begin
                if (cand_valid[i] && cand_valid[j] &&
                    cand_bank[i*BANK_W +: BANK_W] == cand_bank[j*BANK_W +: BANK_W])
                    dup[i] = 1'b1;
            end
        end
        // Longest leading group with distinct banks
        take  = TAKE_W'($countones(cand_valid));
        found = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (dup[i] && !found) begin
                take  = TAKE_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < LANES; i++)
            grant[i] = cand_valid[i] && (TAKE_W'(i) < take);
        repeat_seen = |dup;
    end

    // R3: a non-empty candidate set always grants its first lane
    assert_first_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid[0] |-> grant[0]);

    // R7: a cut-short group always comes with the collision flag
    assert_cut_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != cand_valid) |-> repeat_seen);

endmodule

// File: rtl/prime_stride_agu.sv
module prime_stride_agu
    import prime_agu_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int STRIDE_W  = 16,
    parameter int CNT_W     = 13,
    parameter int LANES     = 16,
    parameter int NUM_BANKS = 17,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int ROW_W     = $clog2((2**ADDR_W - 1) / NUM_BANKS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_valid,
    output logic                       start_ready,
    input  logic [ADDR_W-1:0]          start_addr,
    input  logic signed [STRIDE_W-1:0] start_stride,
    input  logic [CNT_W-1:0]           start_count,
    output logic                       issue_valid,
    output logic [LANES-1:0]           lane_valid,
    output logic [LANES*BANK_W-1:0]    lane_bank,
    output logic [LANES*ROW_W-1:0]     lane_row,
    output logic                       conflict,
    output logic                       done
);
    localparam int TAKE_W = $clog2(LANES + 1);

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   cur;
        logic [STRIDE_W-1:0] stride;
        logic [CNT_W-1:0]    left;
        logic                done;
    } state_t;

    state_t st_q, st_d;

    logic [ADDR_W-1:0]       stride_ext;
    logic [LANES-1:0]        cand_valid;
    logic [LANES*ADDR_W-1:0] lane_addr;
    logic [LANES-1:0]        grant;
    logic [TAKE_W-1:0]       take;
    logic                    repeat_seen;

    assign stride_ext = {{(ADDR_W-STRIDE_W){st_q.stride[STRIDE_W-1]}}, st_q.stride};

    // Per-lane address and bank/row mapping
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_addr[l*ADDR_W +: ADDR_W] =
            st_q.cur + ADDR_W'(stride_ext * ADDR_W'(l));
        assign cand_valid[l] = (st_q.phase == PH_RUN) && (CNT_W'(l) < st_q.left);

        prime_bank_map #(
            .ADDR_W   (ADDR_W),
            .NUM_BANKS(NUM_BANKS),
            .BANK_W   (BANK_W),
            .ROW_W    (ROW_W)
        ) u_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .word_addr(lane_addr[l*ADDR_W +: ADDR_W]),
            .bank     (lane_bank[l*BANK_W +: BANK_W]),
            .row      (lane_row[l*ROW_W +: ROW_W])
        );
    end

    bank_group_scan #(
        .LANES (LANES),
        .BANK_W(BANK_W),
        .TAKE_W(TAKE_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_valid (cand_valid),
        .cand_bank  (lane_bank),
        .grant      (grant),
        .take       (take),
        .repeat_seen(repeat_seen)
    );

    // Next-state logic
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_valid) begin
                    st_d.cur    = start_addr;
                    st_d.stride = start_stride;
                    st_d.left   = start_count;
                    if (start_count == '0) st_d.done  = 1'b1;
                    else                   st_d.phase = PH_RUN;
                end
            end
            PH_RUN: begin
                st_d.cur  = st_q.cur + ADDR_W'(stride_ext * ADDR_W'(take));
                st_d.left = st_q.left - CNT_W'(take);
                if (st_q.left == CNT_W'(take)) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cur: '0, stride: '0, left: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign start_ready = (st_q.phase == PH_IDLE);
    assign issue_valid = (st_q.phase == PH_RUN);
    assign lane_valid  = grant;
    assign conflict    = issue_valid && repeat_seen;
    assign done        = st_q.done;

    // Occupancy map of issued banks, used by the checks below
    logic [NUM_BANKS-1:0] hit_map;
    always_comb begin
        hit_map = '0;
        for (int l = 0; l < LANES; l++)
            if (lane_valid[l]) hit_map[lane_bank[l*BANK_W +: BANK_W]] = 1'b1;
    end

    // R4: issued lanes occupy as many banks as there are lanes
    assert_banks_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ($countones(hit_map) == $countones(lane_valid)));

    // R3: mask is non-empty and contiguous from lane 0
    assert_mask_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (lane_valid != '0 &&
                         (lane_valid & (lane_valid + 1'b1)) == '0));

    // R5: a partial beat without collision is the final one
    assert_partial_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !conflict && !(&lane_valid)) |=> !issue_valid);

    // R6: a collision beat issues a single element
    assert_conflict_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> ($countones(lane_valid) == 1));

    // R8: ready and issuing are mutually exclusive
    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready != issue_valid);

    // R8: issuing only starts after an accepted request
    assert_run_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(issue_valid) |-> $past(start_valid && start_ready));

    // R9: end of issue is marked by done
    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(issue_valid) |-> done);

    // R9: done never overlaps a beat
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !issue_valid);

endmodule

// File: tb/prime_stride_agu_tb.sv
module prime_stride_agu_tb;
    localparam int ADDR_W = 20;
    localparam int STRIDE_W = 16;
    localparam int CNT_W = 13;
    localparam int LANES = 16;
    localparam int NB = 17;
    localparam int BANK_W = 5;
    localparam int ROW_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_valid = 1'b0;
    logic start_ready;
    logic [ADDR_W-1:0] start_addr = '0;
    logic signed [STRIDE_W-1:0] start_stride = '0;
    logic [CNT_W-1:0] start_count = '0;
    logic issue_valid;
    logic [LANES-1:0] lane_valid;
    logic [LANES*BANK_W-1:0] lane_bank;
    logic [LANES*ROW_W-1:0] lane_row;
    logic conflict;
    logic done;

    always #5 clk = ~clk;

    prime_stride_agu u_dut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_addr(start_addr), .start_stride(start_stride), .start_count(start_count),
        .issue_valid(issue_valid), .lane_valid(lane_valid),
        .lane_bank(lane_bank), .lane_row(lane_row),
        .conflict(conflict), .done(done)
    );

    typedef struct { int bank; int row; } exp_t;
    exp_t sbq[$];

    int checks = 0;
    int errors = 0;
    int job_left = 0;
    bit job_mult = 1'b0;
    int beats = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected elements as beats appear
    always @(negedge clk) begin
        int cand;
        int nexp;
        logic [LANES-1:0] emask;
        exp_t e;
        if (rst_n && issue_valid) begin
            cand  = (job_left < LANES) ? job_left : LANES;
            nexp  = job_mult ? 1 : cand;
            emask = LANES'((64'd1 << nexp) - 1);
            chk(lane_valid == emask, job_mult ? "R6" : "R5", "lane mask", lane_valid, emask);
            chk(conflict == (job_mult && cand > 1), job_mult ? "R6" : "R7", "conflict",
                conflict, (job_mult && cand > 1));
            for (int l = 0; l < LANES; l++) begin
                if (lane_valid[l]) begin
                    if (sbq.size() == 0) begin
                        chk(1'b0, "R3", "unexpected element", l, -1);
                    end else begin
                        e = sbq.pop_front();
                        chk(int'(lane_bank[l*BANK_W +: BANK_W]) == e.bank, "R1", "bank",
                            lane_bank[l*BANK_W +: BANK_W], e.bank);
                        chk(int'(lane_row[l*ROW_W +: ROW_W]) == e.row, "R2", "row",
                            lane_row[l*ROW_W +: ROW_W], e.row);
                    end
                end
            end
            job_left -= $countones(lane_valid);
            beats++;
        end
    end

    task automatic run_job(input int addr, input int stride, input int count, input bit inject);
        int exp_beats;
        int waited;
        bit prev_issue;
        exp_t e;
        job_mult = (stride % NB) == 0;
        for (int k = 0; k < count; k++) begin
            e.bank = (addr + k * stride) % NB;
            e.row  = (addr + k * stride) / NB;
            sbq.push_back(e);
        end
        job_left = count;
        beats = 0;
        exp_beats = (count == 0) ? 0 : (job_mult ? count : (count + LANES - 1) / LANES);
        @(negedge clk);
        chk(start_ready == 1'b1, "R8", "ready before request", start_ready, 1);
        start_valid  = 1'b1;
        start_addr   = ADDR_W'(addr);
        start_stride = STRIDE_W'(stride);
        start_count  = CNT_W'(count);
        @(negedge clk);
        start_valid = 1'b0;
        waited = 0;
        prev_issue = 1'b0;
        while (!done && waited < 20000) begin
            if (issue_valid)
                chk(start_ready == 1'b0, "R8", "ready while issuing", start_ready, 0);
            if (inject && waited == 2) begin
                start_valid  = 1'b1;
                start_addr   = ADDR_W'(777);
                start_stride = STRIDE_W'(3);
                start_count  = CNT_W'(9);
            end
            if (inject && waited == 5) start_valid = 1'b0;
            prev_issue = issue_valid;
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1, "R9", "done seen", done, 1);
        chk(issue_valid == 1'b0, "R9", "no beat with done", issue_valid, 0);
        if (count == 0) chk(waited == 0, "R9", "empty request done delay", waited, 0);
        else            chk(prev_issue == 1'b1, "R9", "done follows last beat", prev_issue, 1);
        chk(beats == exp_beats, job_mult ? "R6" : "R5", "beat count", beats, exp_beats);
        chk(sbq.size() == 0, "R3", "elements left in scoreboard", sbq.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done single cycle", done, 0);
        sbq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(start_ready == 1'b1, "R11", "reset ready", start_ready, 1);
        chk(issue_valid == 1'b0, "R11", "reset issue", issue_valid, 0);
        chk(lane_valid == '0, "R11", "reset lanes", lane_valid, 0);
        chk(done == 1'b0 && conflict == 1'b0, "R11", "reset done/conflict", {done, conflict}, 0);
        rst_n = 1'b1;
        run_job(100, 1, 40, 1'b0);          // R5 contiguous
        run_job(5, 2048, 33, 1'b0);         // R5 R7 power-of-two stride
        run_job(50, 17, 5, 1'b0);           // R6
        run_job(1000, 34, 3, 1'b0);         // R6
        run_job(5000, -3, 20, 1'b0);        // R10
        run_job(40000, -2048, 16, 1'b0);    // R10
        run_job(7, 0, 4, 1'b0);             // R6 zero stride
        run_job(123, 5, 0, 1'b0);           // R9 empty request
        run_job(0, 1, 4096, 1'b1);          // R8 start ignored while busy, R5 max count
        run_job((1 << ADDR_W) - 20, 1, 16, 1'b0); // R2 top of address range
        run_job(300, -17, 3, 1'b0);         // R6 R10
        run_job(9, 16, 16, 1'b0);           // R5 single full beat
        run_job(60000, 13, 70, 1'b0);       // R4 R7
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule